// File: doc/BRIEF.md
# UART Receive Status and Interrupt Identification Slice

This block is the receive-side register slice of a 16550-compatible serial port. A receiver that has already framed a character presents it on a one-cycle strobe. The slice stores it either in a 16-entry queue or in a single holding register, depending on the mode. It keeps the line status flags: data ready, overrun, break and transmit-holding empty. It also tracks whether a transmit-holding-empty interrupt is still owed to software. From these it ranks the interrupt sources, answers reads of the identification register and drives one interrupt line.

Software uses a byte-wide register port with single-cycle read and write strobes. Read data is combinational from the current state. The side effects of a read or write take hold at the clock edge that samples the strobe. The register offsets follow the usual 16550 layout because drivers decode them:

| Offset | Read | Write |
|---|---|---|
| 0 | received data | transmit holding |
| 1 | interrupt enables | interrupt enables |
| 2 | interrupt identification | queue control |
| 5 | line status | none |

All other offsets read as zero.

Top module: `uart_rx_status`

## Requirements
- R1: In queue mode (queue-control bit 0 = 1), a byte that arrives while the queue holds 16 entries is dropped. The stored bytes are not touched, and they are read back later in arrival order.
- R2: The occupancy never exceeds 16. A data read in the same cycle as an arrival at a full queue frees a slot first, so the byte is stored and no overrun is flagged.
- R3: An arrival that finds the queue full sets the overrun bit, which is bit 1 of line status.
- R4: In holding mode (queue-control bit 0 = 0), an arrival while data ready (line status bit 0) is set raises overrun. The new byte replaces the held one, and data ready stays set. A data read in the same cycle as the arrival prevents the overrun.
- R5: A line status read clears overrun and break (bit 4). If an overrun or a break event (`brk_seen`) occurs in the same cycle as the read, the event wins and the bit is set afterwards.
- R6: An identification read clears the transmit-empty pending flag only when that read returned the transmit-empty code. Any other returned code leaves the flag pending.
- R7: Identification bits 3:0 return the highest-ranked enabled source. The ranking, from highest, is:
  - line status error: 0110
  - data available: 0100
  - character timeout: 1100
  - transmit empty: 0010
  - none pending: 0001

  Bits 7:6 both equal the queue-mode bit, and bits 5:4 read 0.
- R8: Data available means occupancy ≥ the trigger level in queue mode, and data ready in holding mode. Queue-control bits 7:6 pick the trigger level: 0→1, 1→4, 2→8, 3→14.
- R9: The character timeout is raised in queue mode when the queue is non-empty and 4·CHAR_CYCLES consecutive cycles pass with no arrival and no data read. An arrival or a data read withdraws it.
- R10: A data read with an empty queue returns the most recently removed byte and leaves the occupancy at zero. Data ready follows a non-zero occupancy in queue mode.
- R11: A transmit-holding write clears both the pending flag and line status bit 5. A `tx_hold_empty` pulse sets both, and it wins over a clear in the same cycle. After reset, bit 5 is 1 and the flag is 0.
- R12: `irq` is the OR of three terms, using the interrupt-enable bits:
  - enable bit 0 AND (data available OR timeout)
  - enable bit 1 AND transmit-empty pending
  - enable bit 2 AND (overrun OR break)

  `irq` is therefore high exactly when the identification code is not 0001.
- R13: A queue-control write empties the queue and the holding register when its bit 1 is set or its bit 0 changes the mode. The write also loads the trigger level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_strobe | input | 1 | A received byte is presented this cycle |
| rx_char | input | 8 | Received byte |
| brk_seen | input | 1 | Break condition detected this cycle |
| tx_hold_empty | input | 1 | Transmitter reports its holding register emptied |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same clock cycle, and each pair needs a rule for which one wins.

- **Arrival and data read at a full queue.** The bench fills the queue to 16 and then strobes a byte in the same cycle as a data read. It judges that the byte was kept and that no overrun appeared.
- **Identification read and a fresh transmit-empty pulse.** These are provoked together, both directly and inside a random mix. The mix also collides line status reads with overruns and breaks.

Every read result and the `irq` level are compared, cycle by cycle, with a behavioural model in the bench.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IER  = 3'd1;
  localparam logic [2:0] A_IIR  = 3'd2;
  localparam logic [2:0] A_LSR  = 3'd5;

  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_RLS  = 4'b0110,
    IID_RDA  = 4'b0100,
    IID_CTO  = 4'b1100,
    IID_THRE = 4'b0010
  } iid_e;

  // Trigger-level code to byte count.
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

  // Fixed-priority pick among enabled sources.
  function automatic iid_e iid_pick(input logic rls, input logic rda,
                                    input logic cto, input logic thre);
    if (rls)       iid_pick = IID_RLS;
    else if (rda)  iid_pick = IID_RDA;
    else if (cto)  iid_pick = IID_CTO;
    else if (thre) iid_pick = IID_THRE;
    else           iid_pick = IID_NONE;
  endfunction

endpackage

// File: rtl/uart_rxs_fifo.sv
module uart_rxs_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          pop_done,
  output logic          ovf
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign pop_done = pop & ~empty;
  // A slot freed by a same-cycle read may be reused.
  assign push_ok  = push & (~full | pop_done);
  assign ovf      = push & full & ~pop_done;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok)  wr_ptr <= ptr_inc(wr_ptr);
      if (pop_done) rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_done})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_rxs_timeout.sv
module uart_rxs_timeout #(
  parameter int LIMIT = 32,
  localparam int TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic hit
);

  logic [TW-1:0] idle_cnt;

  assign hit = (idle_cnt == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  idle_cnt <= '0;
    else if (!hit)      idle_cnt <= idle_cnt + 1'b1;
  end

endmodule

// File: rtl/uart_rxs_iid.sv
module uart_rxs_iid
  import uart_rxs_pkg::*;
(
  input  logic [2:0] ier,
  input  logic       line_err,
  input  logic       data_avail,
  input  logic       char_to,
  input  logic       thre_pend,
  output iid_e       iid
);

  assign iid = iid_pick(ier[2] & line_err,
                        ier[0] & data_avail,
                        ier[0] & char_to,
                        ier[1] & thre_pend);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int CHAR_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_strobe,
  input  logic [7:0] rx_char,
  input  logic       brk_seen,
  input  logic       tx_hold_empty,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  localparam int CW       = $clog2(DEPTH + 1);
  localparam int TO_LIMIT = 4 * CHAR_CYCLES;

  // Register access events.
  logic rd_rbr, rd_iir, rd_lsr, wr_thr, wr_ier, wr_fcr;
  assign rd_rbr = reg_rd & (reg_addr == A_DATA);
  assign rd_iir = reg_rd & (reg_addr == A_IIR);
  assign rd_lsr = reg_rd & (reg_addr == A_LSR);
  assign wr_thr = reg_wr & (reg_addr == A_DATA);
  assign wr_ier = reg_wr & (reg_addr == A_IER);
  assign wr_fcr = reg_wr & (reg_addr == A_IIR);

  logic       q_mode;
  logic [1:0] trig_sel;
  logic [2:0] ier_q;
  logic       flush;
  assign flush = wr_fcr & (reg_wdata[1] | (reg_wdata[0] != q_mode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_mode   <= 1'b0;
      trig_sel <= 2'd0;
      ier_q    <= 3'd0;
    end else begin
      if (wr_fcr) begin
        q_mode   <= reg_wdata[0];
        trig_sel <= reg_wdata[7:6];
      end
      if (wr_ier) ier_q <= reg_wdata[2:0];
    end
  end

  // Queue-mode storage.
  logic [7:0]    q_head;
  logic [CW-1:0] q_count;
  logic          q_full, q_empty, q_pop_done, q_ovf;

  uart_rxs_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push     (rx_strobe & q_mode),
    .pop      (rd_rbr & q_mode),
    .din      (rx_char),
    .head     (q_head),
    .count    (q_count),
    .full     (q_full),
    .empty    (q_empty),
    .pop_done (q_pop_done),
    .ovf      (q_ovf)
  );

  logic [7:0] last_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          last_q <= 8'd0;
    else if (q_pop_done) last_q <= q_head;
  end

  // Holding-mode storage.
  logic [7:0] hold_q;
  logic       hold_v;
  logic       hold_ovf;
  assign hold_ovf = ~q_mode & rx_strobe & hold_v & ~rd_rbr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 8'd0;
      hold_v <= 1'b0;
    end else if (flush) begin
      hold_v <= 1'b0;
    end else if (!q_mode) begin
      if (rx_strobe) begin
        hold_q <= rx_char;
        hold_v <= 1'b1;
      end else if (rd_rbr) begin
        hold_v <= 1'b0;
      end
    end
  end

  // Line status.
  logic data_rdy, ovf_evt, oe_q, bi_q, thr_st_q, thre_pend;
  assign data_rdy = q_mode ? ~q_empty : hold_v;
  assign ovf_evt  = q_mode ? q_ovf : hold_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      oe_q <= (oe_q & ~rd_lsr) | ovf_evt;
      bi_q <= (bi_q & ~rd_lsr) | brk_seen;
    end
  end

  // Character timeout.
  logic to_clr, char_to;
  assign to_clr = ~q_mode | q_empty | rx_strobe | rd_rbr | flush;

  uart_rxs_timeout #(.LIMIT(TO_LIMIT)) u_to (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (to_clr),
    .hit   (char_to)
  );

  // Interrupt identification.
  logic data_avail;
  iid_e iid;
  assign data_avail = q_mode ? (32'(q_count) >= 32'(trig_level(trig_sel))) : hold_v;

  uart_rxs_iid u_iid (
    .ier        (ier_q),
    .line_err   (oe_q | bi_q),
    .data_avail (data_avail),
    .char_to    (char_to & q_mode),
    .thre_pend  (thre_pend),
    .iid        (iid)
  );

  logic thre_ack;
  assign thre_ack = rd_iir & (iid == IID_THRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre_pend <= 1'b0;
      thr_st_q  <= 1'b1;
    end else begin
      thre_pend <= tx_hold_empty | (thre_pend & ~wr_thr & ~thre_ack);
      thr_st_q  <= tx_hold_empty | (thr_st_q & ~wr_thr);
    end
  end

  assign irq = (ier_q[2] & (oe_q | bi_q))
             | (ier_q[0] & (data_avail | (char_to & q_mode)))
             | (ier_q[1] & thre_pend);

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = q_mode ? (q_empty ? last_q : q_head) : hold_q;
      A_IER:   reg_rdata = {5'd0, ier_q};
      A_IIR:   reg_rdata = {q_mode, q_mode, 2'b00, iid};
      A_LSR:   reg_rdata = {2'b00, thr_st_q, bi_q, 2'b00, oe_q, data_rdy};
      default: reg_rdata = 8'd0;
    endcase
  end

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_strobe,
  input logic          brk_seen,
  input logic          tx_hold_empty,
  input logic          rd_rbr,
  input logic          rd_lsr,
  input logic          rd_iir,
  input logic          wr_thr,
  input logic          flush,
  input logic          q_mode,
  input logic          q_full,
  input logic [CW-1:0] q_count,
  input logic [7:0]    q_head,
  input logic          hold_v,
  input logic          ovf_evt,
  input logic          oe_q,
  input logic          bi_q,
  input logic          thre_pend,
  input iid_e          iid,
  input logic          irq
);

  p_no_overwrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mode && q_full && rx_strobe && !rd_rbr && !flush) |=> (q_full && q_head == $past(q_head)));

  p_count_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(q_count) <= DEPTH);

  p_oe_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mode && q_full && rx_strobe && !rd_rbr && !flush) |=> oe_q);

  p_hold_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_mode && hold_v && rx_strobe && !rd_rbr && !flush) |=> (oe_q && hold_v));

  p_lsr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ovf_evt && !brk_seen) |=> (!oe_q && !bi_q));

  p_thre_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_pend && rd_iir && iid != IID_THRE && !wr_thr) |=> thre_pend);

  p_thre_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && iid == IID_THRE && !tx_hold_empty) |=> !thre_pend);

  p_irq_iid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iid != IID_NONE));

endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_strobe     (rx_strobe),
  .brk_seen      (brk_seen),
  .tx_hold_empty (tx_hold_empty),
  .rd_rbr        (rd_rbr),
  .rd_lsr        (rd_lsr),
  .rd_iir        (rd_iir),
  .wr_thr        (wr_thr),
  .flush         (flush),
  .q_mode        (q_mode),
  .q_full        (q_full),
  .q_count       (q_count),
  .q_head        (q_head),
  .hold_v        (hold_v),
  .ovf_evt       (ovf_evt),
  .oe_q          (oe_q),
  .bi_q          (bi_q),
  .thre_pend     (thre_pend),
  .iid           (iid),
  .irq           (irq)
);

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;

  localparam int CHAR_CYCLES = 8;
  localparam int LIMIT       = 4 * CHAR_CYCLES;
  localparam int DEPTH       = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_strobe = 1'b0;
  logic [7:0] rx_char = 8'd0;
  logic       brk_seen = 1'b0;
  logic       tx_hold_empty = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  uart_rx_status #(.DEPTH(DEPTH), .CHAR_CYCLES(CHAR_CYCLES)) uut (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_char(rx_char),
    .brk_seen(brk_seen), .tx_hold_empty(tx_hold_empty), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  // Behavioural model state.
  logic [7:0] mq[$];
  logic [7:0] m_last, m_hold;
  bit         m_hv, m_oe, m_bi, m_tp, m_ts, m_fen;
  logic [2:0] m_ier;
  logic [1:0] m_trig;
  int         m_idle;

  function automatic int m_tl();
    case (m_trig)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [3:0] m_code();
    bit rda = m_fen ? (mq.size() >= m_tl()) : m_hv;
    bit cto = m_fen && mq.size() > 0 && m_idle == LIMIT;
    if (m_ier[2] && (m_oe || m_bi)) return 4'b0110;
    if (m_ier[0] && rda)            return 4'b0100;
    if (m_ier[0] && cto)            return 4'b1100;
    if (m_ier[1] && m_tp)           return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic [7:0] m_rdata(input logic [2:0] a);
    bit dr = m_fen ? (mq.size() > 0) : m_hv;
    case (a)
      3'd0: return m_fen ? ((mq.size() > 0) ? mq[0] : m_last) : m_hold;
      3'd1: return {5'd0, m_ier};
      3'd2: return {m_fen, m_fen, 2'b00, m_code()};
      3'd5: return {2'b00, m_ts, m_bi, 2'b00, m_oe, dr};
      default: return 8'd0;
    endcase
  endfunction

  task automatic model_reset();
    mq.delete();
    m_last = 0; m_hold = 0; m_hv = 0; m_oe = 0; m_bi = 0; m_tp = 0; m_ts = 1;
    m_fen = 0; m_ier = 0; m_trig = 0; m_idle = 0;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // One cycle of stimulus; checks read data and irq before the edge, then advances the model.
  task automatic step(input string req, input bit rxv, input logic [7:0] rxb, input bit brk,
                      input bit txe, input bit rd, input bit wr, input logic [2:0] a,
                      input logic [7:0] wd);
    logic [3:0] code;
    bit pop, ov, flush;
    @(negedge clk);
    rx_strobe = rxv; rx_char = rxb; brk_seen = brk; tx_hold_empty = txe;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #2;
    if (rd) check(req, reg_rdata, m_rdata(a));
    check("R12", {7'd0, irq}, {7'd0, m_code() != 4'b0001});
    code = m_code();
    @(posedge clk);
    pop = rd && a == 3'd0;
    ov  = 0;
    if (!m_fen || mq.size() == 0 || rxv || pop) m_idle = 0;
    else if (m_idle < LIMIT) m_idle++;
    if (m_fen) begin
      if (pop && mq.size() > 0) m_last = mq.pop_front();
      if (rxv) begin
        if (mq.size() < DEPTH) mq.push_back(rxb);
        else ov = 1;
      end
    end else begin
      if (rxv) begin
        if (m_hv && !pop) ov = 1;
        m_hold = rxb; m_hv = 1;
      end else if (pop) m_hv = 0;
    end
    if (rd && a == 3'd5) begin m_oe = 0; m_bi = 0; end
    if (ov)  m_oe = 1;
    if (brk) m_bi = 1;
    if ((wr && a == 3'd0) || (rd && a == 3'd2 && code == 4'b0010)) m_tp = 0;
    if (wr && a == 3'd0) m_ts = 0;
    if (txe) begin m_tp = 1; m_ts = 1; end
    if (wr && a == 3'd1) m_ier = wd[2:0];
    if (wr && a == 3'd2) begin
      flush = wd[1] || (wd[0] != m_fen);
      m_fen = wd[0]; m_trig = wd[7:6];
      if (flush) begin mq.delete(); m_hv = 0; m_idle = 0; end
    end
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 0, 0, 3'd0, 0);
  endtask
  task automatic rx(input string req, input logic [7:0] b);
    step(req, 1, b, 0, 0, 0, 0, 3'd0, 0);
  endtask
  task automatic rd(input string req, input logic [2:0] a);
    step(req, 0, 0, 0, 0, 1, 0, a, 0);
  endtask
  task automatic wr(input string req, input logic [2:0] a, input logic [7:0] d);
    step(req, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R7, R11).
    rd("R7", 3'd2);
    rd("R11", 3'd5);

    // Queue mode, fill past full (R13, R1, R2, R3, R10).
    wr("R13", 3'd2, 8'h03);
    wr("R12", 3'd1, 8'h07);
    for (int i = 0; i < DEPTH + 1; i++) rx("R1", 8'h40 + 8'(i));
    rd("R3", 3'd5);
    rd("R7", 3'd2);
    rd("R5", 3'd5);
    for (int i = 0; i < DEPTH; i++) rd("R1", 3'd0);
    rd("R10", 3'd0);
    rd("R10", 3'd5);

    // Arrival and read together at full (R2).
    for (int i = 0; i < DEPTH; i++) rx("R2", 8'h80 + 8'(i));
    step("R2", 1, 8'hAA, 0, 0, 1, 0, 3'd0, 0);
    rd("R2", 3'd5);
    wr("R13", 3'd2, 8'h03);
    rd("R13", 3'd5);

    // Trigger level 4 and timeout (R8, R9).
    wr("R8", 3'd2, 8'h41);
    rx("R8", 8'h11); rx("R8", 8'h12); rx("R8", 8'h13);
    rd("R8", 3'd2);
    rx("R8", 8'h14);
    rd("R8", 3'd2);
    rd("R9", 3'd0);
    for (int i = 0; i < LIMIT + 2; i++) idle("R9");
    rd("R9", 3'd2);
    rd("R9", 3'd0);
    rd("R9", 3'd2);

    // Holding mode overrun (R4).
    wr("R4", 3'd2, 8'h00);
    rx("R4", 8'h21); rx("R4", 8'h22);
    rd("R4", 3'd5);
    rd("R4", 3'd0);
    rx("R4", 8'h23);
    step("R4", 1, 8'h24, 0, 0, 1, 0, 3'd0, 0);
    rd("R4", 3'd5);
    rd("R4", 3'd0);

    // LSR read colliding with break (R5).
    step("R5", 0, 0, 1, 0, 0, 0, 3'd0, 0);
    step("R5", 0, 0, 1, 0, 1, 0, 3'd5, 0);
    rd("R5", 3'd5);
    rd("R5", 3'd5);

    // THRE masked by receive data (R6, R11).
    step("R11", 0, 0, 0, 1, 0, 0, 3'd0, 0);
    rx("R6", 8'h31);
    rd("R6", 3'd2);
    rd("R6", 3'd0);
    rd("R6", 3'd2);
    rd("R6", 3'd2);
    step("R11", 0, 0, 0, 1, 0, 0, 3'd0, 0);
    step("R6", 0, 0, 0, 1, 1, 0, 3'd2, 0);
    rd("R6", 3'd2);
    wr("R11", 3'd0, 8'h55);
    rd("R11", 3'd5);
    rd("R11", 3'd2);

    // Random mix.
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 99);
      bit rxv = ($urandom_range(0, 99) < 35);
      bit brk = ($urandom_range(0, 99) < 3);
      bit txe = ($urandom_range(0, 99) < 6);
      logic [7:0] b = 8'($urandom);
      if (k < 30)      step("R7", rxv, b, brk, txe, 1, 0, 3'd0, 0);
      else if (k < 45) step("R7", rxv, b, brk, txe, 1, 0, 3'd2, 0);
      else if (k < 58) step("R5", rxv, b, brk, txe, 1, 0, 3'd5, 0);
      else if (k < 62) step("R11", rxv, b, brk, txe, 0, 1, 3'd0, b);
      else if (k < 65) step("R12", rxv, b, brk, txe, 0, 1, 3'd1, b);
      else if (k < 67) step("R13", 0, b, brk, txe, 0, 1, 3'd2, {b[7:6], 4'd0, b[1], (b[2] ? ~m_fen : m_fen)});
      else             step("R12", rxv, b, brk, txe, 0, 0, 3'd0, 0);
    end

    @(negedge clk);
    rx_strobe = 0; brk_seen = 0; tx_hold_empty = 0; reg_rd = 0; reg_wr = 0;
    finish_run();
  end

endmodule